// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small fully associative store of page-to-frame mappings. It sits in front of a page table translator. Each lookup presents a page number and the identifier of the address space that is running. The block compares both against every stored entry at once and returns a hit flag and the cached frame number in the same cycle, through purely combinational logic. On a miss the caller fetches the mapping from the page table and offers it on the fill port. The block then stores it so that the next access to that page hits.

Every entry carries the identifier of the address space that owns it, so mappings from several processes can sit side by side and a context switch needs no invalidation. Entries can be pinned. A pinned entry is never chosen as a victim, and flushing by identifier skips it. A fill picks its slot in this order:
1. An entry that already holds the same page and identifier.
2. The lowest-numbered free entry.
3. A round-robin pointer that steps over pinned entries.

When every entry is pinned and nothing matches, the fill is dropped and an error pulse is raised. A flush of all entries and a flush of one identifier are available. Either flush wins over a fill presented in the same cycle.

Top module: `asidTlb`

## Requirements
- R1: With `hit` high, `frame` equals the frame of the one valid entry whose page and identifier both equal `lkPage` and `lkAsid`, in the same cycle. With no such entry, `hit` is 0 and `frame` is 0.
- R2: A fill accepted at a clock edge is visible to lookups from the next cycle on, returning `fillFrame`.
- R3: Entries with the same page number but different identifiers coexist. A lookup only hits the entry tagged with `lkAsid`.
- R4: A fill whose page and identifier already exist in a valid entry overwrites that entry's frame and pinned bit in place. The block never holds two valid entries with the same page and identifier, and this fill never raises `fillErr`.
- R5: Without such a match, a fill goes to the lowest-numbered invalid entry if one exists.
- R6: When all entries are valid, the victim is the first entry that is not pinned, searching upward from a round-robin pointer with wrap-around. The pointer is 0 after reset and moves to the victim index plus one (modulo the entry count) after such an eviction. Other fills leave it unchanged.
- R7: A pinned entry is never replaced by a fill for a different page or identifier.
- R8: If a fill finds no match, no invalid entry and no unpinned entry, it is discarded. `fillErr` is then high for exactly the one cycle after that edge, and it is low at all other times.
- R9: `flushAll` invalidates every entry, pinned ones included, at the clock edge. The pointer is unchanged.
- R10: `flushAsidEn` invalidates exactly the unpinned entries tagged with `flushAsid`. All other entries are kept.
- R11: When `flushAll` or `flushAsidEn` is high, a fill in the same cycle is ignored, with no write and no `fillErr`.
- R12: After reset, every entry is invalid, no lookup hits, and `fillErr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset |
| lkPage | input | PAGE_W | Page number to translate |
| lkAsid | input | ASID_W | Identifier of the current address space |
| hit | output | 1 | Lookup found a matching entry |
| frame | output | FRAME_W | Frame number of the matching entry, 0 on miss |
| fillEn | input | 1 | Store a new mapping this cycle |
| fillPage | input | PAGE_W | Page number of the mapping |
| fillAsid | input | ASID_W | Identifier of the mapping |
| fillFrame | input | FRAME_W | Frame number of the mapping |
| fillWired | input | 1 | Pin the stored entry against eviction |
| flushAll | input | 1 | Invalidate every entry |
| flushAsidEn | input | 1 | Invalidate unpinned entries of one identifier |
| flushAsid | input | ASID_W | Identifier to flush |
| fillErr | output | 1 | Previous cycle's fill was dropped, all entries pinned |

## Verification
The bench keeps a reference model of the entry table and, after every operation, compares every page and identifier pair of a four-entry configuration against it. A design that lets fills reach pinned entries, or that moves its pointer on free-slot fills, then shows up as an evicted mapping surviving or a live mapping vanishing. Dedicated steps cover the following cases:
- A duplicate fill: a design that writes a second slot instead of overwriting would keep a stale frame or evict a neighbour.
- A fill when every entry is pinned: a wrong design would either corrupt a pinned mapping or miss the error pulse.
- A fill collides with each kind of flush in the same cycle.
- A flush by identifier with pinned entries present: a careless design would clear a pinned entry of that identifier.

// File: rtl/tlbPkg.sv
package tlbPkg;

  // Strobes issued by the control unit to the entry array each cycle.
  typedef struct packed {
    logic writeEn;    // write the fill mapping into writeIdx
    logic flushAll;   // clear every entry
    logic flushAsid;  // clear unpinned entries of one identifier
  } tlbStrobe_t;

endpackage

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         stb,
  input  logic [IDX_W-1:0]   writeIdx,
  input  logic [PAGE_W-1:0]  wrPage,
  input  logic [ASID_W-1:0]  wrAsid,
  input  logic [FRAME_W-1:0] wrFrame,
  input  logic               wrWired,
  input  logic [ASID_W-1:0]  flushAsidVal,
  input  logic [PAGE_W-1:0]  lkPage,
  input  logic [ASID_W-1:0]  lkAsid,
  output logic               hit,
  output logic [FRAME_W-1:0] frame,
  output logic [ENTRIES-1:0] matchVec,
  output logic [ENTRIES-1:0] fillMatchVec,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] wiredVec
);

  logic [ENTRIES-1:0][PAGE_W-1:0]  entPage;
  logic [ENTRIES-1:0][ASID_W-1:0]  entAsid;
  logic [ENTRIES-1:0][FRAME_W-1:0] entFrame;

  // Entry storage: flush beats write, flush-all beats flush-by-identifier.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      wiredVec <= '0;
      entPage  <= '0;
      entAsid  <= '0;
      entFrame <= '0;
    end else if (stb.flushAll) begin
      validVec <= '0;
      wiredVec <= '0;
    end else if (stb.flushAsid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (validVec[i] && !wiredVec[i] && entAsid[i] == flushAsidVal)
          validVec[i] <= 1'b0;
      end
    end else if (stb.writeEn) begin
      validVec[writeIdx] <= 1'b1;
      wiredVec[writeIdx] <= wrWired;
      entPage[writeIdx]  <= wrPage;
      entAsid[writeIdx]  <= wrAsid;
      entFrame[writeIdx] <= wrFrame;
    end
  end

  // Parallel compare for the lookup port and for the fill port.
  always_comb begin
    matchVec     = '0;
    fillMatchVec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      matchVec[i]     = validVec[i] && entPage[i] == lkPage && entAsid[i] == lkAsid;
      fillMatchVec[i] = validVec[i] && entPage[i] == wrPage && entAsid[i] == wrAsid;
    end
  end

  // At most one entry matches, so an AND-OR mux is enough.
  always_comb begin
    frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      frame = frame | (entFrame[i] & {FRAME_W{matchVec[i]}});
    end
  end

  assign hit = |matchVec;

endmodule

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic               flushAll,
  input  logic               flushAsidEn,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] wiredVec,
  input  logic [ENTRIES-1:0] fillMatchVec,
  output tlbStrobe_t         stb,
  output logic [IDX_W-1:0]   writeIdx,
  output logic               fillErr
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx, freeIdx, rrIdx;
  logic             matchAny, freeAny, rrAny;
  logic             flushing, useRr, noSlot;

  // Index of the entry already holding the fill mapping.
  always_comb begin
    matchAny = 1'b0;
    matchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!matchAny && fillMatchVec[i]) begin
        matchAny = 1'b1;
        matchIdx = IDX_W'(i);
      end
    end
  end

  // Lowest-numbered free entry.
  always_comb begin
    freeAny = 1'b0;
    freeIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!freeAny && !validVec[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  // First unpinned entry at or after the round-robin pointer, wrapping.
  always_comb begin
    rrAny = 1'b0;
    rrIdx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int j;
      j = (int'(rrPtr) + k) % ENTRIES;
      if (!rrAny && !wiredVec[j]) begin
        rrAny = 1'b1;
        rrIdx = IDX_W'(j);
      end
    end
  end

  assign flushing = flushAll || flushAsidEn;
  assign noSlot   = !matchAny && !freeAny && !rrAny;
  assign useRr    = !matchAny && !freeAny && rrAny;

  always_comb begin
    stb.flushAll  = flushAll;
    stb.flushAsid = flushAsidEn && !flushAll;
    stb.writeEn   = fillEn && !flushing && !noSlot;
    if (matchAny)     writeIdx = matchIdx;
    else if (freeAny) writeIdx = freeIdx;
    else              writeIdx = rrIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr   <= '0;
      fillErr <= 1'b0;
    end else begin
      fillErr <= fillEn && !flushing && noSlot;
      if (stb.writeEn && useRr) begin
        if (int'(rrIdx) == ENTRIES - 1) rrPtr <= '0;
        else                            rrPtr <= rrIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/asidTlb.sv
module asidTlb
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  parameter int ASID_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PAGE_W-1:0]  lkPage,
  input  logic [ASID_W-1:0]  lkAsid,
  output logic               hit,
  output logic [FRAME_W-1:0] frame,
  input  logic               fillEn,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillWired,
  input  logic               flushAll,
  input  logic               flushAsidEn,
  input  logic [ASID_W-1:0]  flushAsid,
  output logic               fillErr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbStrobe_t         stb;
  logic [IDX_W-1:0]   writeIdx;
  logic [ENTRIES-1:0] matchVec, fillMatchVec, validVec, wiredVec;

  tlbCtrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fillEn       (fillEn),
    .flushAll     (flushAll),
    .flushAsidEn  (flushAsidEn),
    .validVec     (validVec),
    .wiredVec     (wiredVec),
    .fillMatchVec (fillMatchVec),
    .stb          (stb),
    .writeIdx     (writeIdx),
    .fillErr      (fillErr)
  );

  tlbDatapath #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W),
    .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .writeIdx     (writeIdx),
    .wrPage       (fillPage),
    .wrAsid       (fillAsid),
    .wrFrame      (fillFrame),
    .wrWired      (fillWired),
    .flushAsidVal (flushAsid),
    .lkPage       (lkPage),
    .lkAsid       (lkAsid),
    .hit          (hit),
    .frame        (frame),
    .matchVec     (matchVec),
    .fillMatchVec (fillMatchVec),
    .validVec     (validVec),
    .wiredVec     (wiredVec)
  );

endmodule

// File: rtl/tlbChecker.sv
module tlbChecker
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [PAGE_W-1:0]  lkPage,
  input logic [ASID_W-1:0]  lkAsid,
  input logic               hit,
  input logic [FRAME_W-1:0] frame,
  input logic               fillEn,
  input logic [PAGE_W-1:0]  fillPage,
  input logic [ASID_W-1:0]  fillAsid,
  input logic [FRAME_W-1:0] fillFrame,
  input logic               flushAll,
  input logic               flushAsidEn,
  input logic               fillErr,
  input tlbStrobe_t         stb,
  input logic [IDX_W-1:0]   writeIdx,
  input logic [ENTRIES-1:0] matchVec,
  input logic [ENTRIES-1:0] fillMatchVec,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] wiredVec
);

  // R4
  unique_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> frame == '0);

  // R7
  wired_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeEn && !(|fillMatchVec)) |-> !wiredVec[writeIdx]);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillErr |-> ($past(fillEn) && !$past(flushAll) && !$past(flushAsidEn)));

  // R9
  flush_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> validVec == '0);

  // R11
  flush_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushAll || flushAsidEn) |-> !stb.writeEn);

  // R2
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillEn) && !$past(flushAll) && !$past(flushAsidEn) && !fillErr &&
     lkPage == $past(fillPage) && lkAsid == $past(fillAsid))
    |-> (hit && frame == $past(fillFrame)));

endmodule

bind asidTlb tlbChecker #(
  .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W),
  .ASID_W(ASID_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .lkPage       (lkPage),
  .lkAsid       (lkAsid),
  .hit          (hit),
  .frame        (frame),
  .fillEn       (fillEn),
  .fillPage     (fillPage),
  .fillAsid     (fillAsid),
  .fillFrame    (fillFrame),
  .flushAll     (flushAll),
  .flushAsidEn  (flushAsidEn),
  .fillErr      (fillErr),
  .stb          (stb),
  .writeIdx     (writeIdx),
  .matchVec     (matchVec),
  .fillMatchVec (fillMatchVec),
  .validVec     (validVec),
  .wiredVec     (wiredVec)
);

// File: tb/asidTlb_tb.sv
module asidTlb_tb;

  localparam int N  = 4;
  localparam int PW = 3;
  localparam int AW = 2;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] lkPage = '0;
  logic [AW-1:0] lkAsid = '0;
  logic          hit;
  logic [FW-1:0] frame;
  logic          fillEn = 1'b0;
  logic [PW-1:0] fillPage = '0;
  logic [AW-1:0] fillAsid = '0;
  logic [FW-1:0] fillFrame = '0;
  logic          fillWired = 1'b0;
  logic          flushAll = 1'b0;
  logic          flushAsidEn = 1'b0;
  logic [AW-1:0] flushAsid = '0;
  logic          fillErr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model of the entry table.
  bit mV[N];
  bit mW[N];
  int mP[N];
  int mA[N];
  int mF[N];
  int mRr = 0;

  always #5 clk = ~clk;

  asidTlb #(.ENTRIES(N), .PAGE_W(PW), .FRAME_W(FW), .ASID_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .lkPage(lkPage), .lkAsid(lkAsid),
    .hit(hit), .frame(frame), .fillEn(fillEn), .fillPage(fillPage),
    .fillAsid(fillAsid), .fillFrame(fillFrame), .fillWired(fillWired),
    .flushAll(flushAll), .flushAsidEn(flushAsidEn), .flushAsid(flushAsid),
    .fillErr(fillErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Applies the slot-choice rules R4/R5/R6/R7/R8 to the model; returns 1 if dropped.
  function automatic bit mdlFill(int p, int a, int f, bit w);
    for (int i = 0; i < N; i++)
      if (mV[i] && mP[i] == p && mA[i] == a) begin
        mF[i] = f; mW[i] = w; return 0;
      end
    for (int i = 0; i < N; i++)
      if (!mV[i]) begin
        mV[i] = 1; mP[i] = p; mA[i] = a; mF[i] = f; mW[i] = w; return 0;
      end
    for (int k = 0; k < N; k++) begin
      int j = (mRr + k) % N;
      if (!mW[j]) begin
        mP[j] = p; mA[j] = a; mF[j] = f; mW[j] = w;
        mRr = (j + 1) % N;
        return 0;
      end
    end
    return 1;
  endfunction

  // Full sweep of all page/identifier pairs against the model (R1, R3).
  task automatic sweep(input string tag);
    for (int p = 0; p < (1 << PW); p++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        bit eh = 0;
        int ef = 0;
        lkPage = PW'(p);
        lkAsid = AW'(a);
        for (int i = 0; i < N; i++)
          if (mV[i] && mP[i] == p && mA[i] == a) begin eh = 1; ef = mF[i]; end
        #1;
        chk(hit == eh, {tag, " R1 hit"}, int'(hit), int'(eh));
        chk(int'(frame) == ef, {tag, " R1 frame"}, int'(frame), ef);
      end
    end
  endtask

  task automatic doFill(input int p, input int a, input int f, input bit w, input string tag);
    bit expErr;
    @(negedge clk);
    fillEn = 1; fillPage = PW'(p); fillAsid = AW'(a); fillFrame = FW'(f); fillWired = w;
    expErr = mdlFill(p, a, f, w);
    @(negedge clk);
    fillEn = 0;
    chk(fillErr == expErr, {tag, " R8 fillErr"}, int'(fillErr), int'(expErr));
    sweep(tag);
    @(negedge clk);
    chk(fillErr == 1'b0, {tag, " R8 single pulse"}, int'(fillErr), 0);
  endtask

  task automatic doFlushAll(input bit withFill, input string tag);
    @(negedge clk);
    flushAll = 1;
    if (withFill) begin fillEn = 1; fillPage = 3'd6; fillAsid = 2'd1; fillFrame = 6'd55; fillWired = 0; end
    for (int i = 0; i < N; i++) begin mV[i] = 0; mW[i] = 0; end
    @(negedge clk);
    flushAll = 0; fillEn = 0;
    chk(fillErr == 1'b0, {tag, " R11 no err"}, int'(fillErr), 0);
    sweep(tag);
  endtask

  task automatic doFlushAsid(input int a, input bit withFill, input string tag);
    @(negedge clk);
    flushAsidEn = 1; flushAsid = AW'(a);
    if (withFill) begin fillEn = 1; fillPage = 3'd6; fillAsid = 2'd1; fillFrame = 6'd56; fillWired = 0; end
    for (int i = 0; i < N; i++) if (mV[i] && !mW[i] && mA[i] == a) mV[i] = 0;
    @(negedge clk);
    flushAsidEn = 0; fillEn = 0;
    chk(fillErr == 1'b0, {tag, " R11 no err"}, int'(fillErr), 0);
    sweep(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fillErr == 1'b0, "R12 err in reset", int'(fillErr), 0);
    rstN = 1;
    sweep("R12 after reset");

    // R5: fills into free entries, lowest first
    doFill(1, 0, 10, 0, "R5 free a");
    doFill(2, 0, 11, 0, "R5 free b");
    doFill(3, 1, 12, 0, "R5 free c");
    doFill(4, 2, 13, 0, "R5 free d");
    // R6: full, round-robin evictions
    doFill(1, 1, 20, 0, "R6 rr 0");
    doFill(6, 3, 21, 0, "R6 rr 1");
    // R4: overwrite in place
    doFill(4, 2, 33, 0, "R4 dup");
    doFill(7, 0, 22, 0, "R6 rr 2");
    doFill(5, 1, 23, 0, "R6 rr 3");
    doFill(0, 0, 24, 0, "R6 rr wrap");

    // R3: same page, different identifiers coexist
    doFlushAll(0, "R9 flush");
    doFill(5, 0, 30, 0, "R3 a0");
    doFill(5, 1, 31, 0, "R3 a1");
    @(negedge clk);
    lkPage = 3'd5; lkAsid = 2'd1; #1;
    chk(hit && frame == 6'd31, "R3 asid1 frame", int'(frame), 31);
    lkAsid = 2'd2; #1;
    chk(!hit, "R3 other asid miss", int'(hit), 0);

    // R7: pinned entries survive repeated fills
    doFlushAll(0, "R9 flush2");
    doFill(1, 0, 40, 1, "R7 pin a");
    doFill(2, 0, 41, 1, "R7 pin b");
    doFill(3, 1, 42, 1, "R7 pin c");
    doFill(4, 0, 43, 0, "R7 free");
    doFill(5, 0, 44, 0, "R7 evict 1");
    doFill(6, 0, 45, 0, "R7 evict 2");
    doFill(7, 0, 46, 0, "R7 evict 3");
    // R10: flush identifier 0 keeps pinned entries
    doFlushAsid(0, 0, "R10 flush asid0");
    doFill(4, 2, 47, 1, "R7 pin d");
    // R8: all pinned, new mapping dropped
    doFill(5, 3, 48, 0, "R8 all pinned");
    doFill(1, 0, 49, 1, "R4 R8 dup when pinned");
    // R11: flush wins over a fill in the same cycle
    doFlushAsid(3, 1, "R11 asid flush + fill");
    doFlushAll(1, "R11 R9 flushall + fill");

    // Near-exhaustive mixed sequence
    for (int i = 0; i < 24; i++) begin
      doFill((i * 5) % 8, (i * 3) % 4, (i * 7 + 1) % 64, (i % 7) == 3, "R6 mix");
      if (i == 11) doFlushAsid(2, 0, "R10 mix");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule